// File: doc/BRIEF.md
# Cascaded 12-Bit Successive-Approximation Sequencer

This block sequences a 12-bit successive-approximation conversion. It is built as two chained register stages. The upper stage works as a shortened 4-bit register and resolves bits 11 down to 8. When it finishes, its completion hands control to the lower stage. The lower stage waits in a cleared state until that handoff, then resolves bits 7 down to 0. The 12-bit trial word drives an external DAC. The single comparator bit is shared by both stages, and the stages never resolve a bit at the same time.

A conversion starts in one of two ways. In strobed mode, a rising edge on the start input begins it. In free-run mode, the block restarts on its own after every finished word, which gives a fresh result every 13 clocks. A single rising start edge begins the upper stage and clears the lower stage on the same clock. The serial output carries all 12 resolved bits back to back, MSB first, with no gap at the handoff between the stages. The end-of-conversion flag rises in the same cycle as the last serial bit and the valid parallel word.

Top module: `sar12_cascade`

## Requirements
- R1: While reset is asserted, and afterwards in strobed mode (free_run = 0) while no start edge arrives, dac, ser and eoc are all 0, whatever the comparator does.
- R2: A rising edge on start (start = 1 now, 0 at the previous clock) begins a new conversion on that clock. In the following cycle dac = 0x800, ser = 0 and eoc = 0. The upper stage is set to its first trial and the lower stage is cleared.
- R3: Each clock in the upper stage keeps the current trial bit when cmp = 1 and clears it when cmp = 0, then sets the next lower bit as the new trial. Bits 7..0 stay 0 throughout. Four clocks after the start clock, dac[11:8] holds the resolved upper nibble and dac[7:0] = 0x80, which is the lower stage's first trial.
- R4: Twelve clocks after the start clock, eoc = 1. Given an ideal comparator (cmp = 1 when dac <= input), dac then equals the input code. eoc stays 0 during the conversion.
- R5: ser is 0 in the start cycle. In each of the next 12 cycles it carries the bit just decided, MSB first, with no gap between bit 8 and bit 7. It is 0 again in every later cycle that eoc stays high.
- R6: In strobed mode, eoc and dac hold their values until the next start edge.
- R7: In free-run mode the block needs no start edge, even straight out of reset. eoc is high for exactly one cycle, and a new conversion begins on the clock after it, so eoc rises every 13 clocks.
- R8: A start edge in the middle of a conversion abandons it. The next cycle shows dac = 0x800 and eoc = 0, and a full conversion follows.
- R9: Holding start high produces only one conversion. With start still high after eoc, the result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| free_run | input | 1 | 1 = restart automatically, 0 = wait for start edges |
| start | input | 1 | Conversion request; only its rising edge acts |
| cmp | input | 1 | Comparator result: 1 keeps the current trial bit |
| dac | output | 12 | Trial and result word to the DAC, upper stage in bits 11..8 |
| ser | output | 1 | Resolved bits, MSB first, 0 when inhibited |
| eoc | output | 1 | Conversion finished; parallel word and serial word complete |

## Verification
The bench converts codes that sit on the stage boundary, such as 0x0FF and 0xF00, together with all-zero and all-one codes. A wrong handoff would lose or duplicate bit 7 at one of these, and a missing start cycle would shift the serial word by one place. Retriggering mid-word and holding start high both target the edge detector. A design that acts on the level of start would restart over and over, and one that ignores a late edge would finish the stale word. Free-run after reset checks that the block never rests in a dead state. The 13-clock period check catches an extra or missing cycle at the restart.

// File: rtl/sar12_cascade.sv
module sar12_cascade #(
  parameter int HI_BITS = 4,
  parameter int LO_BITS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       free_run,
  input  logic                       start,
  input  logic                       cmp,
  output logic [HI_BITS+LO_BITS-1:0] dac,
  output logic                       ser,
  output logic                       eoc
);
  localparam int HP = (HI_BITS > 1) ? $clog2(HI_BITS) : 1;
  localparam int LP = (LO_BITS > 1) ? $clog2(LO_BITS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_DONE} phase_t;

  phase_t              phase;
  logic                start_q;
  logic [HI_BITS-1:0]  hi_q;
  logic [LO_BITS-1:0]  lo_q;
  logic [HP-1:0]       hi_ptr;
  logic [LP-1:0]       lo_ptr;
  logic                ser_q;
  logic                eoc_q;

  wire go      = start & ~start_q;
  wire resting = (phase == S_IDLE) | (phase == S_DONE);
  wire restart = go | (free_run & resting);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      start_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      hi_ptr  <= '0;
      lo_ptr  <= '0;
      ser_q   <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      start_q <= start;
      ser_q   <= 1'b0;
      if (restart) begin
        hi_q   <= {1'b1, {(HI_BITS-1){1'b0}}};
        lo_q   <= '0;
        hi_ptr <= HP'(HI_BITS-1);
        phase  <= S_HI;
        eoc_q  <= 1'b0;
      end else begin
        case (phase)
          S_HI: begin
            hi_q[hi_ptr] <= cmp;
            ser_q        <= cmp;
            if (hi_ptr == '0) begin
              lo_q[LO_BITS-1] <= 1'b1;
              lo_ptr          <= LP'(LO_BITS-1);
              phase           <= S_LO;
            end else begin
              hi_q[hi_ptr - 1'b1] <= 1'b1;
              hi_ptr              <= hi_ptr - 1'b1;
            end
          end
          S_LO: begin
            lo_q[lo_ptr] <= cmp;
            ser_q        <= cmp;
            if (lo_ptr == '0) begin
              phase <= S_DONE;
              eoc_q <= 1'b1;
            end else begin
              lo_q[lo_ptr - 1'b1] <= 1'b1;
              lo_ptr              <= lo_ptr - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dac = {hi_q, lo_q};
  assign ser = ser_q;
  assign eoc = eoc_q;
endmodule

// File: rtl/sar12_cascade_chk.sv
module sar12_cascade_chk #(
  parameter int W  = 12,
  parameter int LO = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         free_run,
  input logic         start,
  input logic         start_q,
  input logic [1:0]   phase,
  input logic [W-1:0] dac,
  input logic         ser,
  input logic         eoc
);
  assert_start_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_q) |=> (dac == {1'b1, {(W-1){1'b0}}}) && !eoc && !ser);

  assert_low_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> (dac[LO-1:0] == '0));

  assert_serial_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && $past(eoc)) |-> !ser);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !free_run && !(start && !start_q)) |=> eoc && $stable(dac));

  assert_eoc_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && free_run) |=> !eoc);
endmodule

bind sar12_cascade sar12_cascade_chk #(.W(HI_BITS+LO_BITS), .LO(LO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .free_run(free_run), .start(start),
  .start_q(start_q), .phase(phase), .dac(dac), .ser(ser), .eoc(eoc)
);

// File: tb/sim_sar12_cascade.sv
`timescale 1ns/1ps
module sim_sar12_cascade;
  logic clk = 1'b0;
  logic rst_n, free_run, start, cmp;
  logic [11:0] dac, vin;
  logic ser, eoc;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sar12_cascade u0 (.clk(clk), .rst_n(rst_n), .free_run(free_run), .start(start),
                    .cmp(cmp), .dac(dac), .ser(ser), .eoc(eoc));

  always @(negedge clk) cmp <= (dac <= vin);

  localparam logic [23:0] VEC [8] = '{
    {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h800, 12'h800}, {12'h7FF, 12'h7FF},
    {12'h0FF, 12'h0FF}, {12'hF00, 12'hF00}, {12'hA5C, 12'hA5C}, {12'h123, 12'h123}};

  task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [11:0] v, input logic [11:0] exp, input bit hold);
    logic [11:0] word = '0;
    bit early = 1'b0;
    @(negedge clk);
    vin = v; start = 1'b1;
    for (int e = 1; e <= 13; e++) begin
      @(posedge clk); @(negedge clk);
      if (e == 1) begin
        if (!hold) start = 1'b0;
        chk(dac == 12'h800 && !ser && !eoc, "R2", dac, 12'h800);
      end else word[13-e] = ser;
      if (e == 5) chk(dac == {exp[11:8], 8'h80}, "R3", dac, {exp[11:8], 8'h80});
      if (e < 13 && eoc) early = 1'b1;
    end
    chk(!early && eoc && dac == exp, "R4", dac, exp);
    chk(word == exp, "R5", word, exp);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk(eoc && dac == exp && !ser, hold ? "R9" : "R6", dac, exp);
    end
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; free_run = 1'b0; start = 1'b0; vin = 12'h555;
    repeat (3) @(negedge clk);
    chk(dac == 0 && !ser && !eoc, "R1", dac, 12'h000);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dac == 0 && !ser && !eoc, "R1", dac, 12'h000);

    foreach (VEC[i]) convert(VEC[i][23:12], VEC[i][11:0], 1'b0);

    // R9: start held high across the whole word
    convert(12'h3C6, 12'h3C6, 1'b1);

    // R8: retrigger in the middle of a word
    @(negedge clk); vin = 12'hFFF; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); vin = 12'h2B1; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    chk(dac == 12'h800 && !eoc, "R8", dac, 12'h800);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(eoc && dac == 12'h2B1, "R8", dac, 12'h2B1);

    // R7: free-run straight out of reset, no start
    rst_n = 1'b0; free_run = 1'b1; vin = 12'h6E9;
    @(negedge clk); rst_n = 1'b1;
    begin
      int n = 0;
      while (!eoc && n < 40) begin @(posedge clk); @(negedge clk); n++; end
      chk(n == 13 && dac == 12'h6E9, "R7", 12'(n), 12'd13);
      @(posedge clk); @(negedge clk);
      chk(!eoc && dac == 12'h800, "R7", dac, 12'h800);
      n = 1;
      vin = 12'h19D;
      while (!eoc && n < 40) begin @(posedge clk); @(negedge clk); n++; end
      chk(n == 13 && dac == 12'h19D, "R7", 12'(n), 12'd13);
    end
    free_run = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule